// File: doc/BRIEF.md
# Write-Protected Seconds Counter

This block is a real-time clock that keeps a 32-bit count of elapsed seconds. A prescaler divides the system clock down to a one-cycle tick, and each tick adds one to the count, which wraps around at 2^32. Software reaches the count through a small register window with 16-bit data. The count is split into an upper half and a lower half. A third location holds an arming bit that must be set before either half can be changed.

A count of zero stands for midnight at the start of 1950. The start of 1970 is therefore 7305 days after zero, which is 631152000 seconds (0x259E9D80). Software works out the count it wants and loads it. To load a full count, software first sets the arming bit, then writes the lower half, then writes the upper half. The write to the upper half also clears the arming bit. At reset the count takes the value on a preset input and the clock starts disarmed.

Top module: `secs_rtc`

## Requirements
- R1: While req_i=1 and we_i=0, rdata_o shows bits 31:16 of the count when addr_i=0x00 and bits 15:0 when addr_i=0x04, in the same cycle. When there is no read, rdata_o is 0.
- R2: A write to addr_i=0x08 sets the arming bit to wdata_i[0]. A read of 0x08 always returns 0.
- R3: A write to 0x00 while armed replaces bits 31:16 with wdata_i and keeps bits 15:0. It also disarms the clock, so a later write to 0x04 is ignored.
- R4: A write to 0x04 while armed replaces bits 15:0 with wdata_i and keeps bits 31:16. The clock stays armed.
- R5: A write to 0x00 or 0x04 while disarmed does not change the count.
- R6: The count goes up by one on every TICK_DIV-th clock edge after reset is released, and 0xFFFFFFFF wraps to 0.
- R7: A read of any address other than 0x00, 0x04 and 0x08 returns 0. A write to such an address changes neither the count nor the arming bit.
- R8: While rst_ni=0, the count equals preset_i and the clock is disarmed.
- R9: If a write that loads the count falls on a tick edge, the written value is stored and that tick is lost. Such a write either loads the upper half, or loads the lower half and keeps the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| preset_i | input | 32 | Count loaded during reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |

## Verification
A software load and a prescaler tick can land on the same clock edge. In that case the load must win and the tick must be dropped. It must never happen that the tick is added on top of the loaded value, or that the other half is incremented. The bench tracks the prescaler phase in its own model and times armed writes of both halves to fall exactly on a tick edge. It then reads both halves and compares them with the written value. Random traffic also lands writes on ticks by chance, and each of these is judged against the same model.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] OFS_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ARM = 8'h08;
endpackage

// File: rtl/secs_rtc_prescale.sv
module secs_rtc_prescale #(
  parameter int TICK_DIV = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/secs_rtc_regs.sv
module secs_rtc_regs
  import secs_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ld_hi_o,
  output logic              ld_lo_o,
  output logic              arm_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic arm_q;
  logic wr, rd;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign ld_hi_o = wr & arm_q & (addr_i == OFS_HI);
  assign ld_lo_o = wr & arm_q & (addr_i == OFS_LO);
  assign arm_o   = arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         arm_q <= 1'b0;
    else if (wr && addr_i == OFS_ARM)    arm_q <= wdata_i[0];
    else if (ld_hi_o)                    arm_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_HI:  rdata_o = count_i[CNT_W-1:DATA_W];
        OFS_LO:  rdata_o = count_i[DATA_W-1:0];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter
  import secs_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  preset_i,
  input  logic              tick_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] count_q;

  assign count_o = count_q;

  // a load wins over a coincident tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= preset_i;
    else if (ld_hi_i) count_q <= {wdata_i, count_q[DATA_W-1:0]};
    else if (ld_lo_i) count_q <= {count_q[CNT_W-1:DATA_W], wdata_i};
    else if (tick_i)  count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int TICK_DIV = 125_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  preset_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic             tick;
  logic             ld_hi, ld_lo, arm_q;
  logic [CNT_W-1:0] count_q;

  secs_rtc_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  secs_rtc_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .count_i (count_q),
    .ld_hi_o (ld_hi),
    .ld_lo_o (ld_lo),
    .arm_o   (arm_q),
    .rdata_o (rdata_o)
  );

  secs_rtc_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (preset_i),
    .tick_i   (tick),
    .ld_hi_i  (ld_hi),
    .ld_lo_i  (ld_lo),
    .wdata_i  (wdata_i),
    .count_o  (count_q)
  );
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk
  import secs_rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CNT_W-1:0]  count_q,
  input logic              arm_q,
  input logic              tick
);
  logic wr, wr_cnt, undef;
  assign wr     = req_i & we_i;
  assign wr_cnt = wr & ((addr_i == OFS_HI) | (addr_i == OFS_LO));
  assign undef  = (addr_i != OFS_HI) & (addr_i != OFS_LO) & (addr_i != OFS_ARM);

  assert_arm_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_ARM) |-> rdata_o == '0);

  assert_hi_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && arm_q && addr_i == OFS_HI) |=>
      (!arm_q && count_q == {$past(wdata_i), $past(count_q[DATA_W-1:0])}));

  assert_lo_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && arm_q && addr_i == OFS_LO) |=>
      (arm_q && count_q == {$past(count_q[CNT_W-1:DATA_W]), $past(wdata_i)}));

  assert_locked_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && !arm_q && !tick) |=> $stable(count_q));

  assert_tick_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !(wr_cnt && arm_q)) |=> count_q == $past(count_q) + 1'b1);

  assert_undef_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && undef) |-> rdata_o == '0);

  assert_undef_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && undef && !tick) |=> ($stable(count_q) && $stable(arm_q)));
endmodule

bind secs_rtc secs_rtc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .count_q (count_q),
  .arm_q   (arm_q),
  .tick    (tick)
);

// File: tb/secs_rtc_tb_top.sv
`timescale 1ns/1ps
module secs_rtc_tb_top;
  localparam int DIV = 37;
  localparam logic [31:0] EPOCH70 = 32'd631152000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] preset_i = EPOCH70;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  secs_rtc #(.TICK_DIV(DIV)) dut_i (
    .clk_i, .rst_ni, .preset_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o
  );

  // reference model built from the requirements
  int          m_pc;
  logic [31:0] m_cnt;
  logic        m_arm;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc <= 0; m_cnt <= preset_i; m_arm <= 1'b0;
    end else begin
      bit t, ld;
      t  = (m_pc == DIV - 1);
      ld = 1'b0;
      m_pc <= t ? 0 : m_pc + 1;
      if (req_i && we_i) begin
        if (addr_i == 8'h08) m_arm <= wdata_i[0];
        else if (addr_i == 8'h00 && m_arm) begin
          m_cnt <= {wdata_i, m_cnt[15:0]}; m_arm <= 1'b0; ld = 1'b1;
        end else if (addr_i == 8'h04 && m_arm) begin
          m_cnt <= {m_cnt[31:16], wdata_i}; ld = 1'b1;
        end
      end
      if (t && !ld) m_cnt <= m_cnt + 1;
    end
  end

  function automatic logic [15:0] exp_rd(logic [7:0] a);
    if (a == 8'h00) return m_cnt[31:16];
    if (a == 8'h04) return m_cnt[15:0];
    return 16'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks are entered and left just after a falling edge
  task automatic wr(logic [7:0] a, logic [15:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 check(tag, {16'h0, rdata_o}, {16'h0, exp_rd(a)});
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic rd_full(logic [31:0] exp, string tag);
    logic [15:0] h;
    req_i = 1'b1; we_i = 1'b0; addr_i = 8'h00;
    #1 h = rdata_o;
    addr_i = 8'h04;
    #1 check(tag, {h, rdata_o}, exp);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_tick_next();
    while (m_pc != DIV - 1) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0D5));
    #3;
    #1 check("R8 reset hi", {16'h0, rdata_o}, 32'h0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: preset loaded and clock disarmed
    rd_full(EPOCH70, "R8 preset");
    wr(8'h00, 16'h1234);
    wr(8'h04, 16'h5678);
    rd_full(m_cnt, "R8 disarmed after reset");
    check("R5 locked write ignored", m_cnt[15:0] != 16'h5678 ? 32'h1 : 32'h0, 32'h1);
    rd(8'h08, "R2 arm reads zero");
    // R4: armed low write keeps arm
    wr(8'h08, 16'h0001);
    rd(8'h08, "R2 armed reads zero");
    wr(8'h04, 16'hFFF0);
    rd(8'h04, "R4 low load");
    wr(8'h04, 16'hFFFE);
    rd(8'h04, "R4 still armed");
    // R3: high write disarms
    wr(8'h00, 16'hFFFF);
    rd_full(m_cnt, "R3 high load");
    wr(8'h04, 16'h0000);
    rd(8'h04, "R3 disarmed after high");
    // R7 undefined offsets
    wr(8'h08, 16'h0001);
    wr(8'h0C, 16'h0000);
    wr(8'h05, 16'hAAAA);
    rd(8'h0C, "R7 undef read");
    rd(8'h02, "R7 undef read");
    wr(8'h04, 16'hFFFF);
    rd(8'h04, "R7 undef write kept arm");
    wr(8'h00, 16'hFFFF);
    // R6 wrap: count now near 0xFFFFFFFF
    repeat (3 * DIV) @(negedge clk_i);
    rd_full(m_cnt, "R6 wrap");
    check("R6 wrapped small", m_cnt < 32'h10 ? 32'h1 : 32'h0, 32'h1);
    // R6 tick period
    begin
      logic [31:0] c0;
      wait_tick_next();
      @(negedge clk_i);
      c0 = m_cnt;
      repeat (DIV - 1) @(negedge clk_i);
      rd_full(c0, "R6 no tick early");
      rd_full(c0 + 1, "R6 tick at period");
    end
    // R9 collisions
    wr(8'h08, 16'h0001);
    wait_tick_next();
    wr(8'h04, 16'h4242);
    rd_full(m_cnt, "R9 low load on tick");
    check("R9 low value", {16'h0, m_cnt[15:0]}, 32'h4242);
    wait_tick_next();
    wr(8'h00, 16'h1357);
    rd_full({16'h1357, 16'h4242}, "R9 high load on tick");
    wait_tick_next();
    wr(8'h00, 16'h9999);
    rd_full(m_cnt, "R9 locked write tick applies");
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int sel;
      logic [7:0] a;
      sel = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        default: a = 8'($urandom);
      endcase
      if (sel < 4) wr(a, 16'($urandom));
      else if (sel < 8) rd(a, "R1 random read");
      else rd_full(m_cnt, "R6 random full");
    end
    // R8 reset again mid-run
    preset_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 ;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_full(32'hDEAD_BEEF, "R8 re-reset preset");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule